// File: doc/BRIEF.md
# Interleaved Stereo Sample Queues with Threshold Events

This block gives a stereo audio serial port one transmit queue and one receive queue. Each queue holds left and right samples interleaved in one store, always starting with a left sample. Software loads transmit samples and unloads receive samples through a small register bus. Separate addresses stand for the left and the right slot. The serializer pops transmit samples, and the deserializer pushes receive samples tagged with their channel.

Each channel has a space threshold for each direction. These thresholds drive sticky event flags and DMA requests. The flags also record transmit underruns and receive overruns for each channel. Flags are cleared by writing ones to them. A mask selects which flags raise the interrupt line. A coarse status word shows full and empty per channel, and a clear bit for each direction empties its queue.

Top module: `stereo_fifo_ctrl`

## Requirements
- R1: Transmit writes must alternate between channels, starting with left (address 4 = left, 5 = right). A write to the channel that is not due next is dropped and changes nothing.
- R2: Each channel of a queue holds at most DEPTH/2 samples. A transmit write to a channel holding DEPTH/2 samples is dropped. Status word (address 1) bit 17 is set when the left transmit channel is full and bit 16 when the right one is full.
- R3: A 3-bit threshold code selects 2, 4, 8 or 16 words for codes 0, 1, 2 and 3; codes 4 to 7 select 16. Control (address 0) holds the transmit left code in bits 10:8, transmit right in 14:12, receive left in 18:16 and receive right in 22:20.
- R4: The transmit trigger flag of a channel (flag bit 2 left, 3 right) is set on every cycle in which that channel's free space (DEPTH/2 minus its count) is at least its threshold.
- R5: The receive trigger flag of a channel (bit 6 left, 7 right) is set on every cycle in which that channel's stored count is at least its threshold.
- R6: A serializer pop while the transmit queue is empty leaves the queue unchanged and sets the underrun flag of the channel due next (bit 0 left, 1 right).
- R7: A deserializer push is dropped when the receive queue is full or when its channel is not the one due next. The push then sets the overrun flag of its own channel (bit 4 left, 5 right).
- R8: Receive reads at address 6 (left) and 7 (right) must alternate starting with left. A read of the wrong channel, or of an empty queue, returns 0 and removes nothing. Status bit 1 is set when the left receive channel is empty and bit 0 when the right one is empty.
- R9: Flags (address 2) are sticky. Writing a 1 to a bit clears it, unless the same cycle sets it again, in which case the set wins.
- R10: The interrupt output is high exactly when some flag bit is set and its bit in the mask register (address 3) is set.
- R11: While control bit 0 (transmit) or bit 1 (receive) is set, that queue is held empty and its channel order restarts at left. Control reads back with only its defined bits.
- R12: The transmit DMA request equals control bit 2 AND the transmit trigger condition of either channel. The receive DMA request equals control bit 3 AND the receive trigger condition of either channel.
- R13: The serializer sees samples in the order they were accepted, with a channel indicator that is 0 for left and 1 for right. Read data appears on the register bus the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tx_pop | input | 1 | Serializer takes the head sample |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_sample | output | DW | Head transmit sample |
| tx_sample_right | output | 1 | Head sample belongs to the right channel |
| rx_push | input | 1 | Deserializer offers a sample |
| rx_push_right | input | 1 | Offered sample is a right-channel sample |
| rx_sample | input | DW | Offered receive sample |
| irq | output | 1 | Masked OR of all flags |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
On every cycle, the assertions check that an empty-queue pop records a left underrun. They check that a left push into a full receive queue records an overrun, and that uncleared flags never drop. They also check that a full left transmit channel refuses a write, that a transmit clear empties the queue, that an empty left receive read returns zero, and that a zero mask keeps the interrupt low. Only the bench's scenarios can show the other behaviours. These are the channel alternation rules for writes and reads, the decoding of the threshold codes into trigger levels, the exact status bit positions, and the sample order seen by the serializer. The bench checks these against a behavioural queue model that it compares on every clock.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_FLAGS  = 3'd2;
  localparam logic [2:0] A_MASK   = 3'd3;
  localparam logic [2:0] A_TXL    = 3'd4;
  localparam logic [2:0] A_TXR    = 3'd5;
  localparam logic [2:0] A_RXL    = 3'd6;
  localparam logic [2:0] A_RXR    = 3'd7;

  localparam int NFLAG = 8;
  localparam int F_TXU = 0;  // +1 for right
  localparam int F_TXT = 2;
  localparam int F_RXO = 4;
  localparam int F_RXT = 6;

  // threshold code to words
  function automatic logic [5:0] thr_words(input logic [2:0] code);
    case (code)
      3'd0:    thr_words = 6'd2;
      3'd1:    thr_words = 6'd4;
      3'd2:    thr_words = 6'd8;
      default: thr_words = 6'd16;
    endcase
  endfunction
endpackage

// File: rtl/queue_ram.sv
module queue_ram #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/stereo_queue.sv
module stereo_queue #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH/2 + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          wr_right,
  output logic          rd_right,
  output logic [CW-1:0] cnt_l,
  output logic [CW-1:0] cnt_r,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wp, rp;
  logic [CW:0]   total;
  logic          do_push, do_pop;
  logic          inc_l, inc_r, dec_l, dec_r;

  assign total   = {1'b0, cnt_l} + {1'b0, cnt_r};
  assign full    = (total == (CW+1)'(DEPTH));
  assign empty   = (total == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign inc_l   = do_push && !wr_right;
  assign inc_r   = do_push &&  wr_right;
  assign dec_l   = do_pop  && !rd_right;
  assign dec_r   = do_pop  &&  rd_right;

  queue_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_push),
    .waddr (wp),
    .wdata (push_data),
    .raddr (rp),
    .rdata (head)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp       <= '0;
      rp       <= '0;
      wr_right <= 1'b0;
      rd_right <= 1'b0;
      cnt_l    <= '0;
      cnt_r    <= '0;
    end else begin
      if (do_push) begin
        wp       <= wp + 1'b1;
        wr_right <= ~wr_right;
      end
      if (do_pop) begin
        rp       <= rp + 1'b1;
        rd_right <= ~rd_right;
      end
      cnt_l <= cnt_l + CW'(inc_l) - CW'(dec_l);
      cnt_r <= cnt_r + CW'(inc_r) - CW'(dec_r);
    end
  end
endmodule

// File: rtl/stereo_fifo_ctrl.sv
module stereo_fifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int HALF = DEPTH / 2,
  localparam int CW   = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_pop,
  output logic          tx_avail,
  output logic [DW-1:0] tx_sample,
  output logic          tx_sample_right,
  input  logic          rx_push,
  input  logic          rx_push_right,
  input  logic [DW-1:0] rx_sample,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  // control state
  logic             tx_clr, rx_clr, tx_dma_en, rx_dma_en;
  logic [2:0]       thr_code [4];   // txL, txR, rxL, rxR
  logic [NFLAG-1:0] flags_q, mask_q, set_v, w1c;
  logic [31:0]      ctrl_word, status_word;

  // queue views
  logic [DW-1:0] rx_head;
  logic          tx_wr_right, tx_rd_right, rx_wr_right, rx_rd_right;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt_l, tx_cnt_r, rx_cnt_l, rx_cnt_r;
  logic [CW-1:0] tx_cnt [2];
  logic [CW-1:0] rx_cnt [2];
  logic [1:0]    tx_trig, rx_trig;

  // access decode
  logic tx_wr, tx_wr_ch, tx_accept;
  logic rx_rd, rx_rd_ch, rx_rd_ok, rx_accept;
  logic underrun, overrun;

  assign tx_wr     = reg_wr && (reg_addr == A_TXL || reg_addr == A_TXR);
  assign tx_wr_ch  = (reg_addr == A_TXR);
  assign tx_accept = tx_wr && (tx_wr_ch == tx_wr_right) &&
                     ((tx_wr_ch ? tx_cnt_r : tx_cnt_l) != CW'(HALF));
  assign rx_rd     = reg_rd && (reg_addr == A_RXL || reg_addr == A_RXR);
  assign rx_rd_ch  = (reg_addr == A_RXR);
  assign rx_rd_ok  = rx_rd && (rx_rd_ch == rx_rd_right) && !rx_empty;
  assign rx_accept = rx_push && !rx_full && (rx_push_right == rx_wr_right);
  assign underrun  = tx_pop && tx_empty;
  assign overrun   = rx_push && !rx_accept;

  stereo_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .clr       (tx_clr),
    .push      (tx_accept),
    .push_data (reg_wdata[DW-1:0]),
    .pop       (tx_pop),
    .head      (tx_sample),
    .wr_right  (tx_wr_right),
    .rd_right  (tx_rd_right),
    .cnt_l     (tx_cnt_l),
    .cnt_r     (tx_cnt_r),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  stereo_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .clr       (rx_clr),
    .push      (rx_accept),
    .push_data (rx_sample),
    .pop       (rx_rd_ok),
    .head      (rx_head),
    .wr_right  (rx_wr_right),
    .rd_right  (rx_rd_right),
    .cnt_l     (rx_cnt_l),
    .cnt_r     (rx_cnt_r),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign tx_cnt[0] = tx_cnt_l;
  assign tx_cnt[1] = tx_cnt_r;
  assign rx_cnt[0] = rx_cnt_l;
  assign rx_cnt[1] = rx_cnt_r;

  // per-channel threshold comparators
  for (genvar ch = 0; ch < 2; ch++) begin : g_trig
    assign tx_trig[ch] = (int'(HALF) - int'(tx_cnt[ch])) >= int'(thr_words(thr_code[ch]));
    assign rx_trig[ch] = int'(rx_cnt[ch]) >= int'(thr_words(thr_code[2+ch]));
  end

  always_comb begin
    set_v                    = '0;
    set_v[F_TXU]             = underrun && !tx_rd_right;
    set_v[F_TXU+1]           = underrun &&  tx_rd_right;
    set_v[F_TXT]             = tx_trig[0];
    set_v[F_TXT+1]           = tx_trig[1];
    set_v[F_RXO]             = overrun && !rx_push_right;
    set_v[F_RXO+1]           = overrun &&  rx_push_right;
    set_v[F_RXT]             = rx_trig[0];
    set_v[F_RXT+1]           = rx_trig[1];
    w1c = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;
  end

  always_comb begin
    ctrl_word = {9'b0, thr_code[3], 1'b0, thr_code[2], 1'b0, thr_code[1],
                 1'b0, thr_code[0], 4'b0, rx_dma_en, tx_dma_en, rx_clr, tx_clr};
    status_word     = '0;
    status_word[17] = (tx_cnt_l == CW'(HALF));
    status_word[16] = (tx_cnt_r == CW'(HALF));
    status_word[1]  = (rx_cnt_l == '0);
    status_word[0]  = (rx_cnt_r == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_clr    <= 1'b0;
      rx_clr    <= 1'b0;
      tx_dma_en <= 1'b0;
      rx_dma_en <= 1'b0;
      for (int i = 0; i < 4; i++) thr_code[i] <= '0;
      mask_q    <= '0;
      flags_q   <= '0;
      reg_rdata <= '0;
    end else begin
      flags_q <= (flags_q & ~w1c) | set_v;
      if (reg_wr && reg_addr == A_CTRL) begin
        tx_clr      <= reg_wdata[0];
        rx_clr      <= reg_wdata[1];
        tx_dma_en   <= reg_wdata[2];
        rx_dma_en   <= reg_wdata[3];
        thr_code[0] <= reg_wdata[10:8];
        thr_code[1] <= reg_wdata[14:12];
        thr_code[2] <= reg_wdata[18:16];
        thr_code[3] <= reg_wdata[22:20];
      end
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NFLAG-1:0];
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:   reg_rdata <= ctrl_word;
          A_STATUS: reg_rdata <= status_word;
          A_FLAGS:  reg_rdata <= 32'(flags_q);
          A_MASK:   reg_rdata <= 32'(mask_q);
          default:  reg_rdata <= rx_rd_ok ? 32'(rx_head) : '0;
        endcase
      end
    end
  end

  assign tx_avail        = !tx_empty;
  assign tx_sample_right = tx_rd_right;
  assign irq             = |(flags_q & mask_q);
  assign tx_dma_req      = tx_dma_en && (|tx_trig);
  assign rx_dma_req      = rx_dma_en && (|rx_trig);
endmodule

// File: rtl/stereo_fifo_chk.sv
module stereo_fifo_chk #(
  parameter int CW   = 5,
  parameter int HALF = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          tx_pop,
  input logic          tx_avail,
  input logic          tx_sample_right,
  input logic          rx_push,
  input logic          rx_push_right,
  input logic          rx_full,
  input logic          tx_clr,
  input logic [CW-1:0] tx_cnt_l,
  input logic [CW-1:0] rx_cnt_l,
  input logic [7:0]    flags_q,
  input logic [7:0]    mask_q,
  input logic          irq
);
  logic [7:0] keep;
  assign keep = flags_q & ~((reg_wr && reg_addr == 3'd2) ? reg_wdata[7:0] : 8'h00);

  // R6
  tx_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_avail && !tx_sample_right) |=> flags_q[0]);

  // R7
  rx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rx_push_right) |=> flags_q[4]);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(keep)) == $past(keep)));

  // R2
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd4 && tx_cnt_l == CW'(HALF) && !tx_pop) |=> (tx_cnt_l == CW'(HALF)));

  // R11
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> !tx_avail);

  // R8
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd6 && rx_cnt_l == '0) |=> (reg_rdata == 32'h0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 8'h00) |-> !irq);
endmodule

bind stereo_fifo_ctrl stereo_fifo_chk #(.CW(CW), .HALF(HALF)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .reg_wr          (reg_wr),
  .reg_rd          (reg_rd),
  .reg_addr        (reg_addr),
  .reg_wdata       (reg_wdata),
  .reg_rdata       (reg_rdata),
  .tx_pop          (tx_pop),
  .tx_avail        (tx_avail),
  .tx_sample_right (tx_sample_right),
  .rx_push         (rx_push),
  .rx_push_right   (rx_push_right),
  .rx_full         (rx_full),
  .tx_clr          (tx_clr),
  .tx_cnt_l        (tx_cnt_l),
  .rx_cnt_l        (rx_cnt_l),
  .flags_q         (flags_q),
  .mask_q          (mask_q),
  .irq             (irq)
);

// File: tb/tb_stereo_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_stereo_fifo_ctrl;
  localparam int DW = 24;
  localparam int DEPTH = 32;
  localparam int HALF = DEPTH / 2;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic tx_pop = 0, tx_avail, tx_sample_right;
  logic [DW-1:0] tx_sample;
  logic rx_push = 0, rx_push_right = 0;
  logic [DW-1:0] rx_sample = 0;
  logic irq, tx_dma_req, rx_dma_req;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R13";

  stereo_fifo_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int txq[$], rxq[$];
  bit twp, trp, rwp, rrp;
  logic [31:0] m_ctrl, m_rdata;
  logic [7:0] m_flags, m_mask;

  function automatic int thr(input logic [2:0] c);
    return (c >= 3) ? 16 : (2 << c);
  endfunction
  function automatic int lefts(input int n, input bit rph);
    return rph ? n / 2 : (n + 1) / 2;
  endfunction
  function automatic bit txtrig(input int ch);
    int l = lefts(txq.size(), trp);
    int c = ch ? txq.size() - l : l;
    return (HALF - c) >= thr(ch ? m_ctrl[14:12] : m_ctrl[10:8]);
  endfunction
  function automatic bit rxtrig(input int ch);
    int l = lefts(rxq.size(), rrp);
    int c = ch ? rxq.size() - l : l;
    return c >= thr(ch ? m_ctrl[22:20] : m_ctrl[18:16]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      twp = 0; trp = 0; rwp = 0; rrp = 0;
      m_ctrl = 0; m_rdata = 0; m_flags = 0; m_mask = 0;
    end else begin
      logic [7:0] s, w;
      int txl, txr, rxl, rxr;
      bit do_txpush, do_txpop, do_rxpush, do_rxpop;
      txl = lefts(txq.size(), trp); txr = txq.size() - txl;
      rxl = lefts(rxq.size(), rrp); rxr = rxq.size() - rxl;
      s = 0;
      s[2] = txtrig(0); s[3] = txtrig(1);
      s[6] = rxtrig(0); s[7] = rxtrig(1);
      do_txpop = tx_pop && txq.size() > 0;
      if (tx_pop && txq.size() == 0) s[trp] = 1;
      do_rxpush = rx_push && rxq.size() < DEPTH && rx_push_right == rwp;
      if (rx_push && !do_rxpush) s[4 + rx_push_right] = 1;
      do_txpush = reg_wr && (reg_addr == 4 || reg_addr == 5) &&
                  ((reg_addr == 5) == twp) && (((reg_addr == 5) ? txr : txl) < HALF);
      do_rxpop = reg_rd && (reg_addr == 6 || reg_addr == 7) &&
                 ((reg_addr == 7) == rrp) && rxq.size() > 0;
      w = (reg_wr && reg_addr == 2) ? reg_wdata[7:0] : 8'h0;
      if (reg_rd) begin
        case (reg_addr)
          0: m_rdata = m_ctrl;
          1: m_rdata = {14'b0, txl == HALF, txr == HALF, 14'b0, rxl == 0, rxr == 0};
          2: m_rdata = {24'b0, m_flags};
          3: m_rdata = {24'b0, m_mask};
          default: m_rdata = do_rxpop ? rxq[0] : 0;
        endcase
      end
      m_flags = (m_flags & ~w) | s;
      if (do_txpop) begin void'(txq.pop_front()); trp = ~trp; end
      if (do_txpush) begin txq.push_back(reg_wdata[DW-1:0]); twp = ~twp; end
      if (do_rxpop) begin void'(rxq.pop_front()); rrp = ~rrp; end
      if (do_rxpush) begin rxq.push_back(rx_sample); rwp = ~rwp; end
      if (m_ctrl[0]) begin txq.delete(); twp = 0; trp = 0; end
      if (m_ctrl[1]) begin rxq.delete(); rwp = 0; rrp = 0; end
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata & 32'h0077_770F;
      if (reg_wr && reg_addr == 3) m_mask = reg_wdata[7:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " tx_avail"}, 32'(tx_avail), 32'(txq.size() > 0));
      chk({cur_req, " irq"}, 32'(irq), 32'(|(m_flags & m_mask)));
      chk({cur_req, " tx_dma"}, 32'(tx_dma_req), 32'(m_ctrl[2] && (txtrig(0) || txtrig(1))));
      chk({cur_req, " rx_dma"}, 32'(rx_dma_req), 32'(m_ctrl[3] && (rxtrig(0) || rxtrig(1))));
      chk({cur_req, " rdata"}, reg_rdata, m_rdata);
      if (txq.size() > 0) begin
        chk({cur_req, " tx_sample"}, 32'(tx_sample), 32'(txq[0]));
        chk({cur_req, " tx_chan"}, 32'(tx_sample_right), 32'(trp));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 0;
    @(negedge clk); d = reg_rdata;
  endtask
  task automatic pop();
    @(negedge clk); tx_pop = 1;
    @(posedge clk); #1 tx_pop = 0;
  endtask
  task automatic push(input bit right, input logic [DW-1:0] d);
    @(negedge clk); rx_push = 1; rx_push_right = right; rx_sample = d;
    @(posedge clk); #1 rx_push = 0;
  endtask
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // reset state
    cur_req = "R11";
    rd(0, v); chk("R11 ctrl after reset", v, 32'h0);
    rd(1, v); chk("R2 status after reset", v, 32'h3);
    rd(2, v); chk("R4 flags after reset", v, 32'h0C);
    chk("R10 irq after reset", 32'(irq), 0);

    // alternation and order
    cur_req = "R1";
    wr(5, 32'h333); settle(); chk("R1 right-first rejected", 32'(tx_avail), 0);
    wr(4, 32'h111); wr(4, 32'h222); wr(5, 32'h333); settle();
    chk("R13 head sample", 32'(tx_sample), 32'h111);
    chk("R13 head chan", 32'(tx_sample_right), 0);
    pop(); settle();
    chk("R1 second left dropped", 32'(tx_sample), 32'h333);
    chk("R13 right chan", 32'(tx_sample_right), 1);
    pop(); settle(); chk("R13 drained", 32'(tx_avail), 0);

    // underrun and W1C
    cur_req = "R6";
    pop(); rd(2, v); chk("R6 left underrun", v & 32'h3, 32'h1);
    cur_req = "R9";
    wr(2, 32'hFF); rd(2, v); chk("R9 w1c with re-set", v, 32'h0C);

    // fill, full drop, status
    cur_req = "R2";
    for (int i = 0; i < HALF; i++) begin
      wr(4, 2 * i); wr(5, 2 * i + 1);
    end
    wr(4, 32'hBAD);
    rd(1, v); chk("R2 tx full status", v, 32'h0003_0003);
    cur_req = "R4";
    wr(2, 32'hFF); rd(2, v); chk("R4 no space no trigger", v & 32'h0C, 0);
    cur_req = "R3";
    wr(0, 32'h0000_7100);
    rd(0, v); chk("R11 ctrl readback", v, 32'h0000_7100);
    for (int i = 0; i < 8; i++) begin
      settle(); chk("R13 fifo order", 32'(tx_sample), i); pop();
    end
    wr(2, 32'hFF); rd(2, v); chk("R3 code1=4 met, code7=16 not", v & 32'h0C, 32'h04);
    cur_req = "R13";
    for (int i = 8; i < DEPTH; i++) begin
      settle(); chk("R13 fifo order", 32'(tx_sample), i); pop();
    end
    settle(); chk("R2 dropped write absent", 32'(tx_avail), 0);

    // DMA gating
    cur_req = "R12";
    wr(0, 32'h4); settle(); chk("R12 tx dma", 32'(tx_dma_req), 1);
    wr(0, 32'h8); settle(); chk("R12 rx dma idle", 32'(rx_dma_req), 0);
    chk("R12 tx dma off", 32'(tx_dma_req), 0);

    // clear
    cur_req = "R11";
    wr(0, 32'h0); wr(4, 1); wr(5, 2); wr(0, 32'h1); wr(0, 32'h0); settle();
    chk("R11 tx cleared", 32'(tx_avail), 0);
    wr(5, 3); settle(); chk("R11 order restarts left", 32'(tx_avail), 0);
    wr(4, 4); settle(); chk("R11 left accepted", 32'(tx_sample), 4);
    wr(0, 32'h1); wr(0, 32'h0);

    // receive thresholds, overrun, reads
    cur_req = "R5";
    wr(0, 32'h0032_0000);
    for (int i = 0; i < 16; i++) push(i[0], 24'h100 + i);
    wr(2, 32'hFF); rd(2, v); chk("R5 rx left at 8", v & 32'hC0, 32'h40);
    for (int i = 16; i < DEPTH; i++) push(i[0], 24'h100 + i);
    cur_req = "R7";
    wr(2, 32'hFF); push(0, 24'hBAD); rd(2, v); chk("R7 full overrun left", v & 32'h30, 32'h10);
    cur_req = "R8";
    rd(1, v); chk("R8 rx not empty", v & 32'h3, 0);
    rd(7, v); chk("R8 right-first read", v, 0);
    rd(6, v); chk("R8 left read", v, 32'h100);
    rd(6, v); chk("R8 repeated left", v, 0);
    rd(7, v); chk("R8 right read", v, 32'h101);
    cur_req = "R7";
    wr(2, 32'hFF); push(1, 24'hBAD); rd(2, v); chk("R7 out-of-order right", v & 32'h30, 32'h20);
    cur_req = "R10";
    wr(3, 32'h20); settle(); chk("R10 irq masked in", 32'(irq), 1);
    wr(2, 32'h20); settle(); chk("R10 irq cleared", 32'(irq), 0);
    cur_req = "R12";
    wr(0, 32'h0032_0008); settle(); chk("R12 rx dma", 32'(rx_dma_req), 1);
    cur_req = "R11";
    wr(0, 32'h2); wr(0, 32'h0); rd(1, v); chk("R11 rx cleared", v & 32'h3, 32'h3);
    rd(6, v); chk("R8 empty read zero", v, 0);

    repeat (4) @(negedge clk);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule